// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a synchronous DRAM from the moment reset is released until the memory can accept normal traffic. During the settling window after power-up it keeps the clock enable high and puts only no-operation commands on the bus. It then closes every bank with a precharge-all, performs a configurable number of auto-refresh cycles, programs the normal mode register and, when asked to, the extended mode register. Only after the last mode write has had its settling time does it raise a ready flag, at which point a memory controller may take over the bus.

All spacing between commands is derived at elaboration time from nanosecond-scale minimum timings (given in picoseconds) and the clock period, rounded up to whole clocks. The mode register contents and the choice of whether to write the extended register are sampled while reset is held. Once ready, the block also accepts a request to rewrite the extended mode register on its own, without a new power-up sequence; the requester must guarantee that all banks are idle at that time.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is high, and in the first cycle after a reset edge, the outputs show clock enable high, a no-op command, bank and address zero, and the ready flag low.
- R2: After reset is released, only no-ops are driven for PWR clocks, PWR = ceil(T_PWRUP_PS / CLK_PS); the precharge-all appears in output cycle PWR-1, counting the first cycle after the first non-reset edge as cycle 0.
- R3: Precharge-all is encoded as {cs_n, ras_n, cas_n, we_n} = 0010 with address bit 10 high and all other address and bank bits low.
- R4: max(2, REFRESH_COUNT) auto refreshes (command 0001, address and bank zero) follow; the first comes RP = ceil(T_RP_PS / CLK_PS) clocks after the precharge, each next one RC = ceil(T_RC_PS / CLK_PS) clocks after the previous.
- R5: RC clocks after the last refresh the normal mode write (command 0000, bank 00) is issued with the mode word sampled during reset on the address bus.
- R6: If the extended write was enabled at reset, MRD clocks after the normal mode write an extended mode write (command 0000, bank 10) carries the extended word sampled at reset; otherwise none is issued.
- R7: MRD = max(2, T_MRD_CLK); the ready flag rises exactly MRD clocks after the last mode write and then stays high until an update request is accepted.
- R8: Changes to the configuration inputs after reset release do not alter the words written or whether the extended write occurs.
- R9: When ready is high and an update request is seen at a clock edge, the next output cycle carries an extended mode write (bank 10) with the update word, ready is low for exactly MRD cycles starting there, and no-ops fill the gap.
- R10: An update request while ready is low has no effect on the command sequence.
- R11: Every cycle without a command carries a no-op (0111) with bank and address zero and clock enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is sampled while high |
| cfg_mode_word | input | ROW_W | Normal mode register value |
| cfg_ext_word | input | ROW_W | Extended mode register value |
| cfg_ext_en | input | 1 | Issue the extended mode write during power-up |
| upd_req | input | 1 | Request an extended mode rewrite (honoured only while ready) |
| upd_ext_word | input | ROW_W | Extended mode value for an update request |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ROW_W | Address bus |
| init_done | output | 1 | Memory ready for normal use |

## Verification
The bench builds two instances side by side: one with a 7.5 ns period, 100 ns settle time, three refreshes and a three-clock mode gap (14, 3 and 9 clocks for the settle, precharge and refresh spacings), and one whose refresh count and mode gap are set below their floors with sub-clock timings, so that the clamps to two refreshes, two-clock mode spacing and one-clock gaps are reached. Every output cycle of both is compared with a schedule computed arithmetically, for runs with the extended write enabled and disabled, with configuration inputs and update requests changed right after reset release, and with an extended rewrite requested after ready.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    // Command code on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } cmd_t;

    // Next action the sequencer will take when its wait expires
    typedef enum logic [2:0] {
        PH_PRE,
        PH_REF,
        PH_MRS,
        PH_EMRS,
        PH_FIN,
        PH_DONE
    } phase_t;

    localparam logic [1:0] BA_STD = 2'b00;
    localparam logic [1:0] BA_EXT = 2'b10;
    localparam int PRE_ALL_BIT = 10;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_boot_timer.sv
module sdram_boot_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R2: a new gap is only started once the previous one has run out
    a_r2_load_after_expiry: assert property (@(posedge clk) disable iff (rst)
        load |-> (cnt == '0));

endmodule

// File: rtl/sdram_boot_refcnt.sv
module sdram_boot_refcnt #(
    parameter int N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic last
);

    localparam int W = $clog2(N + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (step && (cnt != W'(N))) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == W'(N - 1));

    // R4: never more refreshes than configured
    a_r4_refresh_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= W'(N));

endmodule

// File: rtl/sdram_boot_cmdreg.sv
module sdram_boot_cmdreg
    import sdram_boot_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int BA_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  cmd_t             cmd,
    input  logic [BA_W-1:0]  ba,
    input  logic [ROW_W-1:0] addr,
    output logic             cke_o,
    output logic             cs_n_o,
    output logic             ras_n_o,
    output logic             cas_n_o,
    output logic             we_n_o,
    output logic [BA_W-1:0]  ba_o,
    output logic [ROW_W-1:0] addr_o
);

    always_ff @(posedge clk) begin
        cke_o <= 1'b1;
        if (rst || !issue) begin
            {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= CMD_NOP;
            ba_o   <= '0;
            addr_o <= '0;
        end else begin
            {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= cmd;
            ba_o   <= ba;
            addr_o <= addr;
        end
    end

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int ROW_W         = 13,
    parameter int BA_W          = 2,
    parameter int CLK_PS        = 7500,
    parameter int T_PWRUP_PS    = 200_000_000,
    parameter int T_RP_PS       = 19_000,
    parameter int T_RC_PS       = 64_000,
    parameter int T_MRD_CLK     = 2,
    parameter int REFRESH_COUNT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ROW_W-1:0] cfg_mode_word,
    input  logic [ROW_W-1:0] cfg_ext_word,
    input  logic             cfg_ext_en,
    input  logic             upd_req,
    input  logic [ROW_W-1:0] upd_ext_word,
    output logic             sd_cke,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [BA_W-1:0]  sd_ba,
    output logic [ROW_W-1:0] sd_addr,
    output logic             init_done
);

    localparam int PWR_CLK = max2(1, ceil_div(T_PWRUP_PS, CLK_PS));
    localparam int RP_CLK  = max2(1, ceil_div(T_RP_PS, CLK_PS));
    localparam int RC_CLK  = max2(1, ceil_div(T_RC_PS, CLK_PS));
    localparam int MRD_CLK = max2(2, T_MRD_CLK);
    localparam int REF_N   = max2(2, REFRESH_COUNT);
    localparam int MAX_GAP = max2(max2(PWR_CLK, RC_CLK), max2(RP_CLK, MRD_CLK));
    localparam int CNT_W   = $clog2(MAX_GAP + 1);

    localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(RP_CLK - 1);
    localparam logic [CNT_W-1:0] RC_LD  = CNT_W'(RC_CLK - 1);
    localparam logic [CNT_W-1:0] MRD_LD = CNT_W'(MRD_CLK - 1);
    localparam logic [ROW_W-1:0] PRE_ADDR = ROW_W'(1) << PRE_ALL_BIT;

    // Configuration captured while reset is held
    logic [ROW_W-1:0] mode_q;
    logic [ROW_W-1:0] ext_q;
    logic             ext_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= cfg_mode_word;
            ext_q    <= cfg_ext_word;
            ext_en_q <= cfg_ext_en;
        end
    end

    phase_t           ph, ph_n;
    logic             done_q, done_n;
    logic             gap_over;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             ref_step;
    logic             ref_last;
    logic             issue;
    cmd_t             cmd;
    logic [BA_W-1:0]  cmd_ba;
    logic [ROW_W-1:0] cmd_addr;

    sdram_boot_timer #(
        .W       (CNT_W),
        .RST_VAL (PWR_CLK - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (gap_over)
    );

    sdram_boot_refcnt #(
        .N (REF_N)
    ) u_refcnt (
        .clk  (clk),
        .rst  (rst),
        .step (ref_step),
        .last (ref_last)
    );

    always_comb begin
        ph_n     = ph;
        done_n   = done_q;
        issue    = 1'b0;
        cmd      = CMD_NOP;
        cmd_ba   = '0;
        cmd_addr = '0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ref_step = 1'b0;
        if (ph == PH_DONE) begin
            if (done_q && upd_req) begin
                issue    = 1'b1;
                cmd      = CMD_MRS;
                cmd_ba   = BA_W'(BA_EXT);
                cmd_addr = upd_ext_word;
                tmr_load = 1'b1;
                tmr_val  = MRD_LD;
                done_n   = 1'b0;
                ph_n     = PH_FIN;
            end
        end else if (gap_over) begin
            unique case (ph)
                PH_PRE: begin
                    issue    = 1'b1;
                    cmd      = CMD_PRE;
                    cmd_addr = PRE_ADDR;
                    tmr_load = 1'b1;
                    tmr_val  = RP_LD;
                    ph_n     = PH_REF;
                end
                PH_REF: begin
                    issue    = 1'b1;
                    cmd      = CMD_REF;
                    tmr_load = 1'b1;
                    tmr_val  = RC_LD;
                    ref_step = 1'b1;
                    ph_n     = ref_last ? PH_MRS : PH_REF;
                end
                PH_MRS: begin
                    issue    = 1'b1;
                    cmd      = CMD_MRS;
                    cmd_ba   = BA_W'(BA_STD);
                    cmd_addr = mode_q;
                    tmr_load = 1'b1;
                    tmr_val  = MRD_LD;
                    ph_n     = ext_en_q ? PH_EMRS : PH_FIN;
                end
                PH_EMRS: begin
                    issue    = 1'b1;
                    cmd      = CMD_MRS;
                    cmd_ba   = BA_W'(BA_EXT);
                    cmd_addr = ext_q;
                    tmr_load = 1'b1;
                    tmr_val  = MRD_LD;
                    ph_n     = PH_FIN;
                end
                PH_FIN: begin
                    done_n = 1'b1;
                    ph_n   = PH_DONE;
                end
                default: ph_n = PH_DONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_PRE;
            done_q <= 1'b0;
        end else begin
            ph     <= ph_n;
            done_q <= done_n;
        end
    end

    sdram_boot_cmdreg #(
        .ROW_W (ROW_W),
        .BA_W  (BA_W)
    ) u_cmdreg (
        .clk     (clk),
        .rst     (rst),
        .issue   (issue),
        .cmd     (cmd),
        .ba      (cmd_ba),
        .addr    (cmd_addr),
        .cke_o   (sd_cke),
        .cs_n_o  (sd_cs_n),
        .ras_n_o (sd_ras_n),
        .cas_n_o (sd_cas_n),
        .we_n_o  (sd_we_n),
        .ba_o    (sd_ba),
        .addr_o  (sd_addr)
    );

    assign init_done = done_q;

    // R1: reset forces an idle bus and clears ready
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (sd_cke && ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP) && !init_done));

    // R3: a precharge on the bus always closes all banks
    a_r3_pre_all: assert property (@(posedge clk) disable iff (rst)
        ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_PRE) |-> sd_addr[PRE_ALL_BIT]);

    // R7: ready stays up unless an update is requested
    a_r7_ready_holds: assert property (@(posedge clk) disable iff (rst)
        (init_done && !upd_req) |=> init_done);

    // R9: an accepted update puts an extended write on the bus and drops ready
    a_r9_update_write: assert property (@(posedge clk) disable iff (rst)
        (init_done && upd_req) |=> (({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_MRS)
                                    && (sd_ba == BA_W'(BA_EXT)) && !init_done));

endmodule

// File: tb/tb_sdram_boot_seq.sv
module tb_sdram_boot_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] cfg_mode = '0;
    logic [12:0] cfg_ext = '0;
    logic        cfg_ext_en = 1'b0;
    logic        upd_req = 1'b0;
    logic [12:0] upd_word = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    logic        a_cke, a_cs, a_ras, a_cas, a_we, a_done;
    logic [1:0]  a_ba;
    logic [12:0] a_addr;
    logic        b_cke, b_cs, b_ras, b_cas, b_we, b_done;
    logic [1:0]  b_ba;
    logic [12:0] b_addr;

    // main configuration: PWR=14, RP=3, RC=9, 3 refreshes, MRD=3
    sdram_boot_seq #(
        .CLK_PS(7500), .T_PWRUP_PS(100_000), .T_RP_PS(19_000), .T_RC_PS(64_000),
        .T_MRD_CLK(3), .REFRESH_COUNT(3)
    ) dut (
        .clk(clk), .rst(rst), .cfg_mode_word(cfg_mode), .cfg_ext_word(cfg_ext),
        .cfg_ext_en(cfg_ext_en), .upd_req(upd_req), .upd_ext_word(upd_word),
        .sd_cke(a_cke), .sd_cs_n(a_cs), .sd_ras_n(a_ras), .sd_cas_n(a_cas), .sd_we_n(a_we),
        .sd_ba(a_ba), .sd_addr(a_addr), .init_done(a_done)
    );

    // floor configuration: PWR=2, RP=1, RC=1, refreshes clamp to 2, MRD clamps to 2
    sdram_boot_seq #(
        .CLK_PS(7500), .T_PWRUP_PS(10_000), .T_RP_PS(1_000), .T_RC_PS(1_000),
        .T_MRD_CLK(1), .REFRESH_COUNT(1)
    ) dut_min (
        .clk(clk), .rst(rst), .cfg_mode_word(cfg_mode), .cfg_ext_word(cfg_ext),
        .cfg_ext_en(cfg_ext_en), .upd_req(upd_req), .upd_ext_word(upd_word),
        .sd_cke(b_cke), .sd_cs_n(b_cs), .sd_ras_n(b_ras), .sd_cas_n(b_cas), .sd_we_n(b_we),
        .sd_ba(b_ba), .sd_addr(b_addr), .init_done(b_done)
    );

    wire [20:0] act_a = {a_done, a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr};
    wire [20:0] act_b = {b_done, b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr};

    // packed {done, cke, cmd[3:0], ba[1:0], addr[12:0]}
    function automatic logic [20:0] expv(input int n, input int pwr, input int rp, input int rc,
                                         input int nref, input int mrd, input bit ext,
                                         input logic [12:0] mw, input logic [12:0] ew);
        int m;
        int last;
        logic [3:0] c;
        logic [1:0] b;
        logic [12:0] a;
        logic d;
        m    = pwr - 1 + rp + nref * rc;
        last = ext ? m + mrd : m;
        d    = (n >= last + mrd);
        c    = 4'b0111;
        b    = 2'b00;
        a    = '0;
        if (n == pwr - 1) begin c = 4'b0010; a = 13'h0400; end
        for (int i = 0; i < nref; i++)
            if (n == pwr - 1 + rp + i * rc) c = 4'b0001;
        if (n == m) begin c = 4'b0000; a = mw; end
        if (ext && n == m + mrd) begin c = 4'b0000; b = 2'b10; a = ew; end
        return {d, 1'b1, c, b, a};
    endfunction

    function automatic string tag_of(input logic [20:0] e, input int n);
        if (e[18:15] == 4'b0010) return "R3";
        if (e[18:15] == 4'b0001) return "R4";
        if (e[18:15] == 4'b0000 && e[14:13] == 2'b10) return "R6 R8";
        if (e[18:15] == 4'b0000) return "R5 R8";
        if (n < 4) return "R10 R11";
        return "R2 R11";
    endfunction

    task automatic check(input string tag, input logic [20:0] act, input logic [20:0] exp_v);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            if (act[20] !== exp_v[20])
                $display("FAIL R7 (%s) %s: actual=%h expected=%h", tag, "ready flag", act, exp_v);
            else
                $display("FAIL %s: actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic run(input bit ext, input logic [12:0] mw, input logic [12:0] ew,
                       input logic [12:0] uw);
        logic [20:0] ea;
        logic [20:0] eb;
        @(negedge clk);
        rst = 1'b1; cfg_ext_en = ext; cfg_mode = mw; cfg_ext = ew; upd_req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", act_a, {2'b01, 4'b0111, 2'b00, 13'h0});
        check("R1", act_b, {2'b01, 4'b0111, 2'b00, 13'h0});
        rst = 1'b0;
        // R8 and R10: disturb configuration and request updates right after release
        cfg_mode = ~mw; cfg_ext = ~ew; cfg_ext_en = ~ext;
        upd_req = 1'b1; upd_word = 13'h1555;
        for (int n = 0; n < 60; n++) begin
            @(posedge clk);
            @(negedge clk);
            ea = expv(n, 14, 3, 9, 3, 3, ext, mw, ew);
            eb = expv(n, 2, 1, 1, 2, 2, ext, mw, ew);
            check(tag_of(ea, n), act_a, ea);
            check(tag_of(eb, n), act_b, eb);
            if (n == 3) upd_req = 1'b0;
        end
        // R9: extended rewrite after ready
        upd_req = 1'b1; upd_word = uw;
        @(posedge clk);
        @(negedge clk);
        upd_req = 1'b0;
        check("R9", act_a, {2'b01, 4'b0000, 2'b10, uw});
        check("R9", act_b, {2'b01, 4'b0000, 2'b10, uw});
        for (int j = 1; j <= 6; j++) begin
            @(posedge clk);
            @(negedge clk);
            check("R9 R11", act_a, {(j >= 3), 1'b1, 4'b0111, 2'b00, 13'h0});
            check("R9 R11", act_b, {(j >= 2), 1'b1, 4'b0111, 2'b00, 13'h0});
        end
    endtask

    initial begin
        run(1'b0, 13'h0032, 13'h0002, 13'h0041);
        run(1'b1, 13'h0230, 13'h0021, 13'h0062);
        run(1'b1, 13'h1ABC, 13'h0543, 13'h1FFF);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule